// File: doc/BRIEF.md
# SPI Transmit Character Unpacker

This block sits between a host that writes 32-bit words and a serial data line. Each host write carries one to four bytes, chosen by per-lane byte enables, and the enabled bytes enter a byte-wide transmit queue in lane order. A serializer takes bytes from the head of the queue, builds characters of a programmable length between 4 and 16 bits, and shifts them out one bit per clock on `sdo`, with `sdo_vld` marking each valid bit.

Characters of 8 bits or fewer take one byte each. Longer characters take a byte pair: low bits in the first byte and the upper bits right-aligned in the second. The reverse mode changes the line order to msb first and, for 16-bit characters only, swaps the pair so that it is read big-endian. A frame is started with a character count. The block sends that many characters and then discards whatever bytes are still queued. A registered not-full flag tells the host when another full word fits. An over-long write is dropped and raises a sticky error flag.

Top module: `spi_tx_unpacker`

## Requirements
- R1: The character length is `len_sel`+1 bits. A `len_sel` value below 3 is treated as 3, giving 4-bit characters.
- R2: For lengths 4 to 8, each queued byte holds one character, right-aligned with its lsb in bit 0 of the byte. Bytes are sent in queue order.
- R3: For lengths 9 to 16 with reverse clear, a character uses two bytes: the first gives bits 7:0 and the second gives the remaining upper bits, right-aligned. With first byte 0xFB and second byte 0x05 at length 11, the line carries 1,1,0,1,1,1,1,1,1,0,1.
- R4: At length 16 with reverse set, the first byte of the pair gives bits 15:8 and the second gives bits 7:0.
- R5: With reverse clear, characters go out lsb first. With reverse set, they go out msb first. Each bit is valid for exactly one cycle with `sdo_vld` high.
- R6: A write queues only the lanes whose `wr_be` bit is set, as a byte count equal to the number of set bits. They are queued from lane 0 (`wr_data[7:0]`) up to lane 3 (`wr_data[31:24]`), and disabled lanes are skipped.
- R7: `tx_not_full` is high after reset. From the clock edge that applies a write or a read, it is high exactly when the queue holds at most depth minus 4 bytes (28 for the default depth of 32).
- R8: A write with more enabled bytes than free entries is dropped entirely and sets `ovf_err`. That flag stays set until reset.
- R9: A character is only started once the queue holds every byte it needs. Until then, `sdo_vld` stays low and the frame stays busy.
- R10: A `start` pulse while idle latches `len_sel`, `rev_mode` and `frame_chars`, and raises `busy`. A `start` while busy is ignored. After the last bit, `frame_done` pulses for one cycle and `busy` falls.
- R11: When the last character of a frame is taken from the queue, every byte still queued is discarded.
- R12: After reset, `tx_not_full` is 1, and `ovf_err`, `busy`, `sdo_vld` and `frame_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word, lane 0 in bits 7:0 |
| wr_be | input | 4 | Per-lane byte enables |
| len_sel | input | 4 | Character length minus one |
| rev_mode | input | 1 | msb-first order and big-endian 16-bit pairs |
| frame_chars | input | FRAME_W | Characters in the next frame |
| start | input | 1 | Begin a frame when idle |
| tx_not_full | output | 1 | A four-byte write fits |
| ovf_err | output | 1 | Sticky dropped-write flag |
| sdo | output | 1 | Serial data out |
| sdo_vld | output | 1 | `sdo` carries a valid bit this cycle |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The serializer is driven with 8-bit characters lsb first, 4-bit characters msb first, 11-bit and 12-bit byte pairs, and 16-bit pairs in both reverse settings. Identical bytes give different characters across these runs, so a wrong lane order, mask or pair swap shows up. Sparse byte enables separate lane compaction from plain lane copying. A frame started before its bytes arrive shows whether the serializer waits for the whole pair. A short frame followed by a fresh write shows whether leftover bytes were flushed. Filling the queue to the brim, then pushing more, separates a dropped write from a partial one, because the full 32-byte contents are then sent and compared.

// File: rtl/spi_txu_pkg.sv
package spi_txu_pkg;

  // Build one character from the two head bytes, then bit-reverse it when
  // the line order is msb first, so the shifter always emits bit 0 next.
  function automatic logic [15:0] build_char(input logic [7:0] b0,
                                             input logic [7:0] b1,
                                             input logic [3:0] lm1,
                                             input logic       rev);
    logic [15:0] raw;
    logic [15:0] msk;
    logic [15:0] res;
    int          idx;
    if (lm1 <= 4'd7)               raw = {8'h00, b0};
    else if (rev && lm1 == 4'd15)  raw = {b0, b1};
    else                           raw = {b1, b0};
    msk = 16'((17'h1 << (int'(lm1) + 1)) - 17'h1);
    raw = raw & msk;
    res = raw;
    if (rev) begin
      res = '0;
      for (int i = 0; i < 16; i++) begin
        if (i <= int'(lm1)) begin
          idx = int'(lm1) - i;
          res[i] = raw[idx[3:0]];
        end
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/spi_txu_fifo.sv
module spi_txu_fifo #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be,
  input  logic [1:0]    pop_n,
  input  logic          flush,
  output logic [7:0]    rd0,
  output logic [7:0]    rd1,
  output logic [AW:0]   count,
  output logic          not_full,
  output logic          ovf
);
  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [7:0]  cb [4];
  logic [2:0]  nb;
  logic [AW:0] free, cnt_after, count_n;
  logic        accept, reject;

  // compact enabled lanes into consecutive bytes
  always_comb begin
    nb = '0;
    for (int k = 0; k < 4; k++) cb[k] = '0;
    for (int k = 0; k < 4; k++) begin
      if (wr_be[k]) begin
        cb[nb[1:0]] = wr_data[k*8 +: 8];
        nb = nb + 3'd1;
      end
    end
  end

  assign free      = (AW+1)'(DEPTH) - count;
  assign accept    = wr_en && (nb != 3'd0) && ((AW+1)'(nb) <= free);
  assign reject    = wr_en && ((AW+1)'(nb) > free);
  assign cnt_after = flush ? '0 : count - (AW+1)'(pop_n);
  assign count_n   = cnt_after + (accept ? (AW+1)'(nb) : '0);

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (accept && k < int'(nb)) mem[wp + AW'(k)] <= cb[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0; not_full <= 1'b1; ovf <= 1'b0;
    end else begin
      rp       <= flush ? wp : rp + AW'(pop_n);
      wp       <= accept ? wp + AW'(nb) : wp;
      count    <= count_n;
      not_full <= (count_n <= (AW+1)'(DEPTH - 4));
      ovf      <= ovf | reject;
    end
  end

  assign rd0 = mem[rp];
  assign rd1 = mem[rp + AW'(1)];
endmodule

// File: rtl/spi_txu_serial.sv
module spi_txu_serial #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [3:0]         len_sel,
  input  logic               rev_mode,
  input  logic [FRAME_W-1:0] frame_chars,
  input  logic [CNT_W-1:0]   fifo_count,
  input  logic [7:0]         rd0,
  input  logic [7:0]         rd1,
  output logic [1:0]         pop_n,
  output logic               flush,
  output logic               sdo,
  output logic               sdo_vld,
  output logic               busy,
  output logic               frame_done
);
  import spi_txu_pkg::*;

  logic [3:0]         len_q;
  logic               rev_q;
  logic [FRAME_W-1:0] chars_left;
  logic [15:0]        sh;
  logic [4:0]         bits_left;
  logic [1:0]         need;
  logic               can_load;

  assign need     = (len_q > 4'd7) ? 2'd2 : 2'd1;
  assign can_load = busy && (chars_left != '0) && (bits_left <= 5'd1) &&
                    (fifo_count >= CNT_W'(need));
  assign flush    = can_load && (chars_left == FRAME_W'(1));
  assign pop_n    = (can_load && !flush) ? need : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= 4'd3; rev_q <= 1'b0; chars_left <= '0; sh <= '0;
      bits_left <= '0; sdo <= 1'b0; sdo_vld <= 1'b0; busy <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!busy) begin
        sdo_vld <= 1'b0;
        if (start) begin
          busy       <= 1'b1;
          len_q      <= (len_sel < 4'd3) ? 4'd3 : len_sel;
          rev_q      <= rev_mode;
          chars_left <= frame_chars;
          bits_left  <= '0;
        end
      end else begin
        if (bits_left != '0) begin
          sdo       <= sh[0];
          sdo_vld   <= 1'b1;
          sh        <= sh >> 1;
          bits_left <= bits_left - 5'd1;
        end else begin
          sdo_vld <= 1'b0;
        end
        if (can_load) begin
          sh         <= build_char(rd0, rd1, len_q, rev_q);
          bits_left  <= 5'(len_q) + 5'd1;
          chars_left <= chars_left - FRAME_W'(1);
        end else if (chars_left == '0 && bits_left == '0) begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_unpacker.sv
module spi_tx_unpacker #(
  parameter int FIFO_DEPTH = 32,
  parameter int FRAME_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic [3:0]         wr_be,
  input  logic [3:0]         len_sel,
  input  logic               rev_mode,
  input  logic [FRAME_W-1:0] frame_chars,
  input  logic               start,
  output logic               tx_not_full,
  output logic               ovf_err,
  output logic               sdo,
  output logic               sdo_vld,
  output logic               busy,
  output logic               frame_done
);
  localparam int AW = $clog2(FIFO_DEPTH);

  logic [7:0]  rd0, rd1;
  logic [AW:0] fifo_cnt;
  logic [1:0]  pop_n;
  logic        flush;

  spi_txu_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .pop_n(pop_n), .flush(flush), .rd0(rd0), .rd1(rd1), .count(fifo_cnt),
    .not_full(tx_not_full), .ovf(ovf_err)
  );

  spi_txu_serial #(.FRAME_W(FRAME_W), .CNT_W(AW+1)) u_ser (
    .clk(clk), .rst(rst), .start(start), .len_sel(len_sel),
    .rev_mode(rev_mode), .frame_chars(frame_chars), .fifo_count(fifo_cnt),
    .rd0(rd0), .rd1(rd1), .pop_n(pop_n), .flush(flush), .sdo(sdo),
    .sdo_vld(sdo_vld), .busy(busy), .frame_done(frame_done)
  );
endmodule

// File: rtl/spi_txu_chk.sv
module spi_txu_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          ovf_err,
  input logic          sdo_vld,
  input logic          busy,
  input logic          frame_done,
  input logic [CW-1:0] fifo_cnt
);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);
  a_r5_vld_in_frame: assert property (@(posedge clk) disable iff (rst)
    sdo_vld |-> busy);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  a_r10_start_takes: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

bind spi_tx_unpacker spi_txu_chk #(.DEPTH(FIFO_DEPTH), .CW($clog2(FIFO_DEPTH)+1)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ovf_err(ovf_err), .sdo_vld(sdo_vld),
  .busy(busy), .frame_done(frame_done), .fifo_cnt(fifo_cnt)
);

// File: tb/test_spi_tx_unpacker.sv
module test_spi_tx_unpacker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [3:0]  len_sel = 4'd7;
  logic        rev_mode = 1'b0;
  logic [15:0] frame_chars = '0;
  logic        start = 1'b0;
  logic        tx_not_full, ovf_err, sdo, sdo_vld, busy, frame_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int nbits = 0;
  logic bits [0:511];

  spi_tx_unpacker i_spi_tx_unpacker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
    .len_sel(len_sel), .rev_mode(rev_mode), .frame_chars(frame_chars),
    .start(start), .tx_not_full(tx_not_full), .ovf_err(ovf_err), .sdo(sdo),
    .sdo_vld(sdo_vld), .busy(busy), .frame_done(frame_done)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (sdo_vld && nbits < 512) begin
    bits[nbits] = sdo;
    nbits++;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected < 100000", cyc);
      summary();
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int get_char(int idx, int len, bit msb);
    int v = 0;
    for (int i = 0; i < len; i++) begin
      if (msb) v = (v << 1) | int'(bits[idx*len + i]);
      else     v = v | (int'(bits[idx*len + i]) << i);
    end
    return v;
  endfunction

  task automatic push(logic [31:0] d, logic [3:0] be);
    @(negedge clk); wr_en = 1'b1; wr_data = d; wr_be = be;
    @(negedge clk); wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic kick(int n, logic [3:0] ls, logic rv);
    @(negedge clk);
    nbits = 0; len_sel = ls; rev_mode = rv; frame_chars = 16'(n); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!frame_done) @(negedge clk);
    @(negedge clk);
    check("R10 done pulse one cycle", int'(frame_done), 0);
    check("R10 busy falls", int'(busy), 0);
  endtask

  task automatic t_reset();
    check("R12 not_full", int'(tx_not_full), 1);
    check("R12 ovf", int'(ovf_err), 0);
    check("R12 busy", int'(busy), 0);
    check("R12 sdo_vld", int'(sdo_vld), 0);
    check("R12 frame_done", int'(frame_done), 0);
  endtask

  task automatic t_byte_chars();
    push(32'h44332211, 4'hF);
    kick(4, 4'd7, 1'b0); wait_done();
    check("R2 bit count", nbits, 32);
    check("R2 char0", get_char(0, 8, 0), 'h11);
    check("R2 char1", get_char(1, 8, 0), 'h22);
    check("R5 char3 lsb first", get_char(3, 8, 0), 'h44);
  endtask

  task automatic t_nibble_msb();
    push(32'h00005AFC, 4'h3);
    kick(2, 4'd3, 1'b1); wait_done();
    check("R1 4-bit count", nbits, 8);
    check("R5 msb first char0", get_char(0, 4, 1), 'hC);
    check("R5 first bit msb", int'(bits[0]), 1);
    check("R2 char1 masked", get_char(1, 4, 1), 'hA);
  endtask

  task automatic t_example();
    int exp_b [11] = '{1,1,0,1,1,1,1,1,1,0,1};
    push(32'h000005FB, 4'h3);
    kick(1, 4'd10, 1'b0); wait_done();
    check("R3 bit count", nbits, 11);
    for (int i = 0; i < 11; i++) check("R3 example bit", int'(bits[i]), exp_b[i]);
  endtask

  task automatic t_wide();
    push(32'h56781234, 4'hF);
    kick(2, 4'd15, 1'b1); wait_done();
    check("R4 rev pair0", get_char(0, 16, 1), 'h3412);
    check("R4 rev pair1", get_char(1, 16, 1), 'h7856);
    push(32'h56781234, 4'hF);
    kick(2, 4'd15, 1'b0); wait_done();
    check("R3 16-bit pair0", get_char(0, 16, 0), 'h1234);
    check("R3 16-bit pair1", get_char(1, 16, 0), 'h5678);
    push(32'h0000CDAB, 4'h3);
    kick(1, 4'd11, 1'b1); wait_done();
    check("R3 12-bit rev no swap", get_char(0, 12, 1), 'hDAB);
  endtask

  task automatic t_sparse();
    push(32'hDD00BB00, 4'b1010);
    kick(2, 4'd7, 1'b0); wait_done();
    check("R6 count", nbits, 16);
    check("R6 lane1 first", get_char(0, 8, 0), 'hBB);
    check("R6 lane3 second", get_char(1, 8, 0), 'hDD);
  endtask

  task automatic t_wait_bytes();
    kick(1, 4'd11, 1'b0);
    push(32'h00000034, 4'h1);
    @(negedge clk); start = 1'b1; frame_chars = 16'd5;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    check("R9 no bits with half pair", nbits, 0);
    check("R9 still busy", int'(busy), 1);
    push(32'h0000000E, 4'h1);
    wait_done();
    check("R10 restart ignored, one char", nbits, 12);
    check("R9 char", get_char(0, 12, 0), 'hE34);
  endtask

  task automatic t_flush();
    push(32'h44332211, 4'hF);
    kick(1, 4'd7, 1'b0); wait_done();
    check("R11 first", get_char(0, 8, 0), 'h11);
    push(32'h00000099, 4'h1);
    kick(1, 4'd7, 1'b0); wait_done();
    check("R11 leftovers dropped", get_char(0, 8, 0), 'h99);
  endtask

  task automatic t_clamp();
    push(32'h000000F5, 4'h1);
    kick(1, 4'd1, 1'b0); wait_done();
    check("R1 clamp count", nbits, 4);
    check("R1 clamp value", get_char(0, 4, 0), 'h5);
  endtask

  task automatic t_full();
    for (int w = 0; w < 8; w++) begin
      push({8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}, 4'hF);
      if (w == 6) check("R7 28 bytes not_full", int'(tx_not_full), 1);
    end
    check("R7 32 bytes full", int'(tx_not_full), 0);
    check("R8 no ovf yet", int'(ovf_err), 0);
    push(32'hEEEEEEEE, 4'hF);
    check("R8 ovf set", int'(ovf_err), 1);
    push(32'h000000EE, 4'h1);
    kick(32, 4'd7, 1'b0); wait_done();
    check("R8 bits", nbits, 256);
    for (int i = 0; i < 32; i++) check("R8 content intact", get_char(i, 8, 0), i);
    check("R8 ovf sticky", int'(ovf_err), 1);
    check("R7 empty not_full", int'(tx_not_full), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_chars();
    t_nibble_msb();
    t_example();
    t_wide();
    t_sparse();
    t_wait_bytes();
    t_flush();
    t_clamp();
    t_full();
    summary();
  end
endmodule